// File: doc/BRIEF.md
# Module Row Page Size Calculator

This block works out the base-2 logarithm of the row page size, in bits, for both sides of one memory module. It fetches the module's descriptor bytes through a byte request/response port. The byte source is outside the block and may take any number of cycles to answer.

A start pulse launches a fixed fetch sequence. First comes the column-count byte. Next come the two bytes of the 16-bit module data width, most significant first. Then comes the bank count. When the bank count is two, the column byte is fetched once more to size the second side.

The side-one result is the column count in the low nibble plus the floor of log2 of the data width. The side-two result is a copy of side one. When the upper nibble of the second column fetch is non-zero, the low-nibble count is swapped for that upper-nibble count. Failed reads and a zero width set an error flag but do not stop the sequence. A bank count above two raises a separate flag. Results and flags are held with a level done signal until the next start.

Top module: `psz_calc`

## Requirements
- R1: Fetches are issued in the order column byte (field code 0), width high byte (code 1), width low byte (code 2), bank count (code 3). A second column-byte fetch (code 0) follows only when the bank count equals 2. Otherwise done follows the bank count.
- R2: req_o stays high with field_o unchanged until a cycle in which rsp_valid_i is high. Each such cycle consumes exactly one byte.
- R3: side1_o equals the low nibble of the column byte plus the index of the highest set bit of the width {high byte, low byte}.
- R4: side2_o is zero when the bank count is not 2.
- R5: With bank count 2 and a zero upper nibble in the second column fetch, side2_o equals side1_o.
- R6: With bank count 2 and a non-zero upper nibble in the second column fetch, side2_o equals side1_o minus that fetch's low nibble plus its upper nibble, modulo 2^RES_W.
- R7: A bank count above 2 sets bad_banks_o, leaves err_o clear, still yields side1_o, gives side2_o of zero, and issues no further fetch.
- R8: A response with rsp_err_i high sets err_o. The byte is then taken as zero and its data ignored, and the sequence runs on to done.
- R9: A data width of zero gives a log2 of zero and sets err_o.
- R10: done_o rises in the cycle after the last byte is consumed. It stays high with all results and flags unchanged until a start. One cycle after a start, done_o, both results and both flags read zero.
- R11: A start pulse while fetches are in progress is ignored.
- R12: After reset, req_o, done_o, side1_o, side2_o, err_o and bad_banks_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a new calculation |
| req_o | output | 1 | Byte request pending |
| field_o | output | 2 | Requested field code (0 column, 1 width high, 2 width low, 3 banks) |
| rsp_valid_i | input | 1 | Response for the pending request |
| rsp_data_i | input | 8 | Response byte |
| rsp_err_i | input | 1 | Response is a failed read |
| done_o | output | 1 | Results valid, held until next start |
| side1_o | output | RES_W | log2 page size, side one |
| side2_o | output | RES_W | log2 page size, side two |
| err_o | output | 1 | A read failed or the width was zero |
| bad_banks_o | output | 1 | Bank count above 2 |

## Verification
The bench targets the asymmetric module, where a design that reused the first column nibble or added the upper nibble without removing the lower one reports the wrong side-two size. It targets bank counts of one and four: a design that keyed the second fetch on "not one" would issue a stray fetch or leave stale side-two data. It stalls responses and pulses start mid-sequence to catch a design that skips a field or restarts. It injects a failed read and a zero width, where a careless design would stop early, use the garbage byte, or return a bogus log2 without flagging it.

// File: rtl/psz_pkg.sv
package psz_pkg;
  localparam int BYTE_W  = 8;
  localparam int WIDTH_W = 2 * BYTE_W;
  localparam int LOG_W   = $clog2(WIDTH_W);
  localparam int NIB_W   = BYTE_W / 2;

  typedef enum logic [1:0] {
    F_COL   = 2'd0,
    F_WMSB  = 2'd1,
    F_WLSB  = 2'd2,
    F_BANKS = 2'd3
  } field_e;

  typedef enum logic [2:0] {
    S_IDLE, S_COL, S_WMSB, S_WLSB, S_BANKS, S_COL2, S_DONE
  } state_e;
endpackage

// File: rtl/psz_log2.sv
module psz_log2 #(
  parameter int IN_W  = 16,
  parameter int OUT_W = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] lg_o,
  output logic             zero_o
);
  always_comb begin
    lg_o = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (val_i[i]) lg_o = OUT_W'(i);
    end
  end

  assign zero_o = (val_i == '0);

  // highest set bit: shifting down by the result leaves exactly one
  always_comb begin
    if (val_i != '0) begin
      assert_msb_index_R3: assert ((val_i >> lg_o) == IN_W'(1));
    end
  end
endmodule

// File: rtl/psz_seq.sv
module psz_seq
  import psz_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   rsp_valid_i,
  input  logic   pair_i,
  output logic   req_o,
  output field_e field_o,
  output logic   acc_o,
  output logic   second_o,
  output logic   clear_o,
  output logic   done_o
);
  state_e state_q;

  assign req_o    = (state_q != S_IDLE) && (state_q != S_DONE);
  assign acc_o    = req_o && rsp_valid_i;
  assign second_o = (state_q == S_COL2);
  assign done_o   = (state_q == S_DONE);
  assign clear_o  = start_i && !req_o;

  always_comb begin
    unique case (state_q)
      S_WMSB:  field_o = F_WMSB;
      S_WLSB:  field_o = F_WLSB;
      S_BANKS: field_o = F_BANKS;
      default: field_o = F_COL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE: if (start_i) state_q <= S_COL;
        S_COL:   if (acc_o) state_q <= S_WMSB;
        S_WMSB:  if (acc_o) state_q <= S_WLSB;
        S_WLSB:  if (acc_o) state_q <= S_BANKS;
        S_BANKS: if (acc_o) state_q <= pair_i ? S_COL2 : S_DONE;
        S_COL2:  if (acc_o) state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rsp_valid_i) |=> (req_o && $stable(field_o)));

  assert_width_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && field_o == F_WMSB) |=> (req_o && field_o == F_WLSB));

  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && start_i && !rsp_valid_i) |=> (req_o && $stable(field_o)));
endmodule

// File: rtl/psz_dp.sv
module psz_dp
  import psz_pkg::*;
#(
  parameter int RES_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               acc_i,
  input  field_e             field_i,
  input  logic               second_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               rd_err_i,
  input  logic [LOG_W-1:0]   lg_i,
  input  logic               wzero_i,
  output logic [WIDTH_W-1:0] width_o,
  output logic [RES_W-1:0]   side1_o,
  output logic [RES_W-1:0]   side2_o,
  output logic               err_o,
  output logic               bad_o
);
  logic [NIB_W-1:0]  cols_q;
  logic [BYTE_W-1:0] wmsb_q, wlsb_q;
  logic [NIB_W-1:0]  hi_nib, lo_nib;

  assign width_o = {wmsb_q, wlsb_q};
  assign hi_nib  = byte_i[BYTE_W-1:NIB_W];
  assign lo_nib  = byte_i[NIB_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cols_q  <= '0;
      wmsb_q  <= '0;
      wlsb_q  <= '0;
      side1_o <= '0;
      side2_o <= '0;
      err_o   <= 1'b0;
      bad_o   <= 1'b0;
    end else if (clear_i) begin
      cols_q  <= '0;
      wmsb_q  <= '0;
      wlsb_q  <= '0;
      side1_o <= '0;
      side2_o <= '0;
      err_o   <= 1'b0;
      bad_o   <= 1'b0;
    end else if (acc_i) begin
      if (rd_err_i) err_o <= 1'b1;
      unique case (field_i)
        F_COL: begin
          if (!second_i) cols_q <= lo_nib;
          else if (hi_nib != '0)
            side2_o <= side1_o - RES_W'(lo_nib) + RES_W'(hi_nib);
          else
            side2_o <= side1_o;
        end
        F_WMSB: wmsb_q <= byte_i;
        F_WLSB: wlsb_q <= byte_i;
        F_BANKS: begin
          side1_o <= RES_W'(cols_q) + RES_W'(lg_i);
          if (wzero_i) err_o <= 1'b1;
          if (byte_i > BYTE_W'(2)) bad_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/psz_calc.sv
module psz_calc
  import psz_pkg::*;
#(
  parameter int RES_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             req_o,
  output logic [1:0]       field_o,
  input  logic             rsp_valid_i,
  input  logic [7:0]       rsp_data_i,
  input  logic             rsp_err_i,
  output logic             done_o,
  output logic [RES_W-1:0] side1_o,
  output logic [RES_W-1:0] side2_o,
  output logic             err_o,
  output logic             bad_banks_o
);
  field_e              field;
  logic                acc, second, clear, pair, wzero;
  logic [BYTE_W-1:0]   byte_v;
  logic [WIDTH_W-1:0]  width;
  logic [LOG_W-1:0]    lg;

  // failed read contributes a zero byte
  assign byte_v  = rsp_err_i ? '0 : rsp_data_i;
  assign pair    = (byte_v == BYTE_W'(2));
  assign field_o = field;

  psz_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rsp_valid_i (rsp_valid_i),
    .pair_i      (pair),
    .req_o       (req_o),
    .field_o     (field),
    .acc_o       (acc),
    .second_o    (second),
    .clear_o     (clear),
    .done_o      (done_o)
  );

  psz_log2 #(.IN_W(WIDTH_W), .OUT_W(LOG_W)) u_log2 (
    .val_i  (width),
    .lg_o   (lg),
    .zero_o (wzero)
  );

  psz_dp #(.RES_W(RES_W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .acc_i    (acc),
    .field_i  (field),
    .second_i (second),
    .byte_i   (byte_v),
    .rd_err_i (rsp_err_i),
    .lg_i     (lg),
    .wzero_i  (wzero),
    .width_o  (width),
    .side1_o  (side1_o),
    .side2_o  (side2_o),
    .err_o    (err_o),
    .bad_o    (bad_banks_o)
  );

  assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(side1_o) && $stable(side2_o)
                              && $stable(err_o) && $stable(bad_banks_o)));

  assert_restart_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && side1_o == '0 && side2_o == '0 && !err_o));

  assert_bad_no_side2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && bad_banks_o |-> (side2_o == '0 && !req_o));

  assert_no_req_when_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);
endmodule

// File: tb/psz_calc_test.sv
`timescale 1ns/1ps
module psz_calc_test;
  localparam int RES_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic rsp_valid_i = 1'b0;
  logic [7:0] rsp_data_i = '0;
  logic rsp_err_i = 1'b0;
  logic req_o, done_o, err_o, bad_banks_o;
  logic [1:0] field_o;
  logic [RES_W-1:0] side1_o, side2_o;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  psz_calc #(.RES_W(RES_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .req_o(req_o), .field_o(field_o),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .rsp_err_i(rsp_err_i),
    .done_o(done_o), .side1_o(side1_o), .side2_o(side2_o),
    .err_o(err_o), .bad_banks_o(bad_banks_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_log2(input int w);
    int r = 0;
    for (int i = 0; i < 16; i++) if (w[i]) r = i;
    return r;
  endfunction

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic read_byte(input int exp_field, input logic [7:0] data, input bit err);
    while (!req_o) @(negedge clk);
    check(field_o == 2'(exp_field), "R1 field order", int'(field_o), exp_field);
    rsp_valid_i = 1'b1;
    rsp_data_i  = data;
    rsp_err_i   = err;
    @(negedge clk);
    rsp_valid_i = 1'b0;
    rsp_err_i   = 1'b0;
    rsp_data_i  = '0;
  endtask

  task automatic check_out(input string req, input int s1, input int s2, input bit e, input bit b);
    check(done_o == 1'b1, {req, " done"}, int'(done_o), 1);
    check(side1_o == RES_W'(s1), {req, " side1"}, int'(side1_o), s1);
    check(side2_o == RES_W'(s2), {req, " side2"}, int'(side2_o), s2);
    check(err_o == e, {req, " err"}, int'(err_o), int'(e));
    check(bad_banks_o == b, {req, " bad_banks"}, int'(bad_banks_o), int'(b));
  endtask

  task automatic test_reset();
    check(req_o == 1'b0, "R12 req", int'(req_o), 0);
    check(done_o == 1'b0, "R12 done", int'(done_o), 0);
    check(side1_o == '0 && side2_o == '0, "R12 sides", int'(side1_o), 0);
    check(err_o == 1'b0 && bad_banks_o == 1'b0, "R12 flags", int'(err_o), 0);
  endtask

  task automatic test_single_side();
    pulse_start();
    read_byte(0, 8'h0A, 0);
    read_byte(1, 8'h00, 0);
    read_byte(2, 8'h40, 0);
    read_byte(3, 8'h01, 0);
    check_out("R3 R4 single", 10 + ref_log2(16'h0040), 0, 0, 0);
    check(req_o == 1'b0, "R1 no second fetch", int'(req_o), 0);
  endtask

  task automatic test_symmetric();
    int s1 = 9 + ref_log2(16'h0048);
    pulse_start();
    read_byte(0, 8'h09, 0);
    read_byte(1, 8'h00, 0);
    read_byte(2, 8'h48, 0);
    read_byte(3, 8'h02, 0);
    read_byte(0, 8'h09, 0);
    check_out("R5 symmetric", s1, s1, 0, 0);
  endtask

  task automatic test_asymmetric();
    int s1 = 9 + ref_log2(16'h0100);
    int s2 = (s1 - 9 + 10) % (1 << RES_W);
    pulse_start();
    read_byte(0, 8'hA9, 0);
    read_byte(1, 8'h01, 0);
    read_byte(2, 8'h00, 0);
    read_byte(3, 8'h02, 0);
    read_byte(0, 8'hA9, 0);
    check_out("R6 asymmetric", s1, s2, 0, 0);
  endtask

  task automatic test_bad_banks();
    pulse_start();
    read_byte(0, 8'h08, 0);
    read_byte(1, 8'h80, 0);
    read_byte(2, 8'h00, 0);
    read_byte(3, 8'h04, 0);
    check_out("R7 bad banks", 8 + ref_log2(16'h8000), 0, 0, 1);
    @(negedge clk);
    check(req_o == 1'b0, "R7 no extra fetch", int'(req_o), 0);
  endtask

  task automatic test_read_error();
    pulse_start();
    read_byte(0, 8'h0B, 0);
    read_byte(1, 8'hFF, 1);
    read_byte(2, 8'h20, 0);
    read_byte(3, 8'h01, 0);
    check_out("R8 read error", 11 + ref_log2(16'h0020), 0, 1, 0);
  endtask

  task automatic test_zero_width();
    pulse_start();
    read_byte(0, 8'h07, 0);
    read_byte(1, 8'h00, 0);
    read_byte(2, 8'h00, 0);
    read_byte(3, 8'h01, 0);
    check_out("R9 zero width", 7, 0, 1, 0);
  endtask

  task automatic test_stall_and_start();
    pulse_start();
    read_byte(0, 8'h05, 0);
    while (!req_o) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(req_o == 1'b1 && field_o == 2'd1, "R2 hold under stall", int'(field_o), 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(req_o == 1'b1 && field_o == 2'd1, "R11 start ignored", int'(field_o), 1);
    read_byte(1, 8'h02, 0);
    read_byte(2, 8'h00, 0);
    read_byte(3, 8'h01, 0);
    check_out("R11 after stall", 5 + ref_log2(16'h0200), 0, 0, 0);
  endtask

  task automatic test_hold_and_restart();
    int s1 = int'(side1_o);
    repeat (3) @(negedge clk);
    check(done_o == 1'b1, "R10 done held", int'(done_o), 1);
    check(side1_o == RES_W'(s1), "R10 side1 held", int'(side1_o), s1);
    pulse_start();
    check(done_o == 1'b0, "R10 done cleared", int'(done_o), 0);
    check(side1_o == '0, "R10 side1 cleared", int'(side1_o), 0);
    check(err_o == 1'b0 && bad_banks_o == 1'b0, "R10 flags cleared", int'(err_o), 0);
    read_byte(0, 8'h0A, 0);
    read_byte(1, 8'h00, 0);
    read_byte(2, 8'h10, 0);
    read_byte(3, 8'h00, 0);
    check_out("R10 rerun", 10 + ref_log2(16'h0010), 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();
    test_single_side();
    test_symmetric();
    test_asymmetric();
    test_bad_banks();
    test_read_error();
    test_zero_width();
    test_stall_and_start();
    test_hold_and_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule